// File: doc/BRIEF.md
# Cold Reset Boot Vector Sequencer

This block brings a processor out of power-on reset and later handles warm resets. An active-low cold reset input resets it at once, with no clock needed. While cold reset is low, the block holds the shared system reset line low. It turns the board's boot buffer on and points it toward the chip. It gates the external clock output and keeps the 16-bit data bus undriven. Every clock it copies the bus into a boot configuration word. When cold reset rises, capture continues for the two synchronizer cycles and then freezes. The bus controls then flip to normal operation, and the system reset stays low for a programmable number of cycles before it is let go.

After the release, the same reset line becomes an input. When an outside agent pulls it low, the block treats that as a warm reset. The core reset falls and stays low until the line is high again, and then the full hold count runs once more. A warm reset leaves the boot word and the bus controls as they are. The pad is modelled as split pins: `rst_pin_i` is the level read back from the line, and `rst_drive_low` enables the open-drain pull-down. The boot word is handed to the core with a one-cycle strobe. There is no back-pressure, because the word stays stable until the next cold reset.

Top module: `boot_reset_seq`

## Requirements
- R1: While `cold_rst_n` is 0, and without waiting for a clock edge, the outputs are: `rst_drive_low`=1, `core_rst_n`=0, `bus_oe`=0, `buf_oe_n`=0, `buf_dir`=0, `clk_out_en`=0, `boot_valid`=0.
- R2: `boot_word` takes the value of `bus_i` at every clock edge while cold reset is low, which allows a pulse of any length. It also takes the value at the first two edges after `cold_rst_n` rises. After that it holds its value until the next cold reset.
- R3: Within 4 clock edges after `cold_rst_n` rises, `bus_oe`, `buf_oe_n`, `buf_dir` and `clk_out_en` all go to 1, while `rst_drive_low` is still 1 and `core_rst_n` is still 0.
- R4: `rst_drive_low` falls and `core_rst_n` rises together. This happens no earlier than HOLD_CYCLES edges and no later than HOLD_CYCLES+4 edges after `cold_rst_n` rises.
- R5: `boot_valid` is 1 for exactly the first cycle in which `core_rst_n` is 1 after any release, whether the reset was cold or warm.
- R6: After release, `rst_pin_i` going low makes `core_rst_n` fall within 4 edges. `rst_drive_low` stays 0, and the four bus and clock controls stay at 1.
- R7: After a warm request, `core_rst_n` rises no earlier than HOLD_CYCLES edges and no later than HOLD_CYCLES+4 edges after `rst_pin_i` returns high. `boot_word` keeps its value through the warm reset.
- R8: If `cold_rst_n` falls during a warm reset count, the block returns at once to the R1 state. The following cold sequence captures a fresh boot word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| cold_rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_i | input | 1 | Level read back from the shared system reset line |
| bus_i | input | 16 | Data bus level from the pads, sampled as the boot word |
| rst_drive_low | output | 1 | Enables the open-drain pull-down on the system reset line |
| bus_oe | output | 1 | Lets the chip drive the data bus |
| buf_oe_n | output | 1 | Boot buffer enable, active low |
| buf_dir | output | 1 | Boot buffer direction, 0 toward the chip and 1 away from it |
| clk_out_en | output | 1 | Enables the external clock output |
| core_rst_n | output | 1 | Reset to the core, active low |
| boot_word | output | 16 | Captured boot configuration word |
| boot_valid | output | 1 | One-cycle strobe when the core reset is released |

## Verification
Two things can coincide here: a new cold reset and a warm hold count that is already under way. The bench provokes this by pulling the reset line low, letting it go, and dropping `cold_rst_n` about a hundred cycles into the recount. The outputs must show the cold reset state at once, and the next sequence must capture a new random word. A second overlap is the end of capture with a change on the bus. The bench changes `bus_i` right after the second edge following the cold rise, so a capture window that is one cycle too long or too short shows up as a wrong word.

// File: rtl/boot_rst_pkg.sv
package boot_rst_pkg;
  typedef enum logic [2:0] {
    COLD_HOLD   = 3'd0,
    RELEASE_BUS = 3'd1,
    RESET_COUNT = 3'd2,
    RUN         = 3'd3,
    WARM_RESET  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/sync_flag.sv
module sync_flag #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic force_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      pipe[i] <= RST_VAL;
      else if (force_i) pipe[i] <= RST_VAL;
      else if (i == 0)  pipe[i] <= d_i;
      else              pipe[i] <= pipe[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int HOLD_CYCLES = 4096
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    cnt <= '0;
    else if (clr_i) cnt <= '0;
    else if (en_i)  cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == CW'(HOLD_CYCLES - 1));

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!arst_n)
    (en_i && !clr_i && $past(done_o) && $past(en_i) && !$past(clr_i)) |-> 1'b0 || !done_o);
endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_rst_pkg::*;
#(
  parameter int W           = 16,
  parameter int HOLD_CYCLES = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         cold_rst_n,
  input  logic         rst_pin_i,
  input  logic [W-1:0] bus_i,
  output logic         rst_drive_low,
  output logic         bus_oe,
  output logic         buf_oe_n,
  output logic         buf_dir,
  output logic         clk_out_en,
  output logic         core_rst_n,
  output logic [W-1:0] boot_word,
  output logic         boot_valid
);
  seq_state_e state, state_nx;
  logic cold_ok, warm_ok, hold_done, hold_clr, hold_en;

  // cold release: reset synchronizer (asynchronous assert, synchronized release)
  sync_flag #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cold_sync (
    .clk(clk), .arst_n(cold_rst_n), .force_i(1'b0), .d_i(1'b1), .q_o(cold_ok));

  // warm request: held idle while the block itself pulls the line low
  sync_flag #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_warm_sync (
    .clk(clk), .arst_n(cold_rst_n), .force_i(rst_drive_low), .d_i(rst_pin_i), .q_o(warm_ok));

  hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .arst_n(cold_rst_n), .clr_i(hold_clr), .en_i(hold_en), .done_o(hold_done));

  always_comb begin
    state_nx = state;
    unique case (state)
      COLD_HOLD:   if (cold_ok) state_nx = RELEASE_BUS;
      RELEASE_BUS: state_nx = RESET_COUNT;
      RESET_COUNT: if (hold_done) state_nx = RUN;
      RUN:         if (!warm_ok) state_nx = WARM_RESET;
      WARM_RESET:  if (warm_ok && hold_done) state_nx = RUN;
      default:     state_nx = COLD_HOLD;
    endcase
  end

  assign hold_clr = (state == COLD_HOLD) || (state == RUN) ||
                    ((state == WARM_RESET) && !warm_ok);
  assign hold_en  = !hold_clr;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      state      <= COLD_HOLD;
      boot_valid <= 1'b0;
    end else begin
      state      <= state_nx;
      boot_valid <= (state_nx == RUN) && (state != RUN);
    end
  end

  // boot word follows the bus until the synchronized cold release
  always_ff @(posedge clk) begin
    if (!cold_ok) boot_word <= bus_i;
  end

  always_comb begin
    rst_drive_low = (state == COLD_HOLD) || (state == RELEASE_BUS) || (state == RESET_COUNT);
    core_rst_n    = (state == RUN);
    bus_oe        = (state != COLD_HOLD);
    buf_oe_n      = (state != COLD_HOLD);
    buf_dir       = (state != COLD_HOLD);
    clk_out_en    = (state != COLD_HOLD);
  end

  // R1: cold reset state seen at every edge while cold reset is low
  a_r1_cold_outputs: assert property (@(posedge clk)
    !cold_rst_n |-> (rst_drive_low && !core_rst_n && !bus_oe && !buf_oe_n &&
                     !buf_dir && !clk_out_en && !boot_valid));

  a_r2_word_frozen: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $past(cold_ok) |-> $stable(boot_word));

  a_r3_bus_before_release: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $rose(bus_oe) |-> (rst_drive_low && !core_rst_n));

  a_r4_hold_elapsed: assert property (@(posedge clk) disable iff (!cold_rst_n)
    $rose(core_rst_n) |-> $past(hold_done));

  a_r5_valid_single: assert property (@(posedge clk) disable iff (!cold_rst_n)
    boot_valid |=> !boot_valid);

  a_r5_valid_with_release: assert property (@(posedge clk) disable iff (!cold_rst_n)
    boot_valid |-> $rose(core_rst_n));

  a_r6_no_drive_warm: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (state == WARM_RESET) |-> (!rst_drive_low && bus_oe && clk_out_en));

  a_r7_word_kept: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (state == WARM_RESET) |=> $stable(boot_word));
endmodule

// File: tb/boot_reset_seq_bench.sv
module boot_reset_seq_bench;
  localparam int W    = 16;
  localparam int HOLD = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         cold_rst_n = 1'b0;
  logic         ext_low    = 1'b0;
  logic [W-1:0] bus_i      = '0;
  logic         rst_pin_i, rst_drive_low, bus_oe, buf_oe_n, buf_dir, clk_out_en;
  logic         core_rst_n, boot_valid;
  logic [W-1:0] boot_word;

  assign rst_pin_i = ~(rst_drive_low | ext_low);

  boot_reset_seq #(.W(W), .HOLD_CYCLES(HOLD)) u_boot_reset_seq (
    .clk(clk), .cold_rst_n(cold_rst_n), .rst_pin_i(rst_pin_i), .bus_i(bus_i),
    .rst_drive_low(rst_drive_low), .bus_oe(bus_oe), .buf_oe_n(buf_oe_n),
    .buf_dir(buf_dir), .clk_out_en(clk_out_en), .core_rst_n(core_rst_n),
    .boot_word(boot_word), .boot_valid(boot_valid));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] cold_pack_exp();
    return 7'b1000000; // drive, core_rst_n, bus_oe, buf_oe_n, buf_dir, clk_en, valid
  endfunction

  function automatic logic [6:0] pack();
    return {rst_drive_low, core_rst_n, bus_oe, buf_oe_n, buf_dir, clk_out_en, boot_valid};
  endfunction

  function automatic bit in_window(input int k);
    return (k >= HOLD) && (k <= HOLD + 4);
  endfunction

  task automatic cold_seq(input logic [W-1:0] word, input int len, input bit noisy, input string rq);
    int k_bus, k_rel;
    bit ctl_ok, vld;
    @(negedge clk);
    cold_rst_n = 1'b0;
    #1;
    chk(pack() == cold_pack_exp(), rq, "outputs on cold assert", pack(), cold_pack_exp());
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (noisy) bus_i = W'($urandom);
      chk(pack() == cold_pack_exp(), "R1", "outputs during cold hold", pack(), cold_pack_exp());
    end
    bus_i = word;
    @(negedge clk);
    cold_rst_n = 1'b1;
    k_bus = -1; k_rel = -1; ctl_ok = 1'b0; vld = 1'b0;
    for (int k = 1; k <= HOLD + 20 && k_rel < 0; k++) begin
      @(negedge clk);
      if (k == 2) bus_i = ~word ^ W'($urandom & 16'h00ff);
      if (k_bus < 0 && bus_oe) begin
        k_bus  = k;
        ctl_ok = buf_oe_n && buf_dir && clk_out_en && rst_drive_low && !core_rst_n;
      end
      if (core_rst_n) begin
        k_rel = k;
        vld   = boot_valid;
      end
    end
    chk(k_bus >= 1 && k_bus <= 4, "R3", "edges to bus release", k_bus, 4);
    chk(ctl_ok, "R3", "controls at bus release", ctl_ok, 1);
    chk(in_window(k_rel), "R4", "edges to reset release", k_rel, HOLD);
    chk(!rst_drive_low, "R4", "line drive at release", rst_drive_low, 0);
    chk(vld, "R5", "strobe at cold release", vld, 1);
    chk(boot_word == word, "R2", "captured boot word", boot_word, word);
    @(negedge clk);
    chk(!boot_valid, "R5", "strobe one cycle", boot_valid, 0);
  endtask

  task automatic warm_seq(input int low_len, input logic [W-1:0] word);
    int k_fall, k_rel;
    bit vld;
    @(negedge clk);
    ext_low = 1'b1;
    k_fall = -1;
    for (int k = 1; k <= 10 && k_fall < 0; k++) begin
      @(negedge clk);
      if (!core_rst_n) k_fall = k;
    end
    chk(k_fall >= 1 && k_fall <= 4, "R6", "edges to core reset", k_fall, 4);
    chk(!rst_drive_low, "R6", "no line drive in warm", rst_drive_low, 0);
    chk({bus_oe, buf_oe_n, buf_dir, clk_out_en} == 4'hf, "R6", "bus controls in warm",
        {bus_oe, buf_oe_n, buf_dir, clk_out_en}, 4'hf);
    for (int i = 0; i < low_len; i++) begin
      @(negedge clk);
      if (core_rst_n) chk(1'b0, "R6", "core reset held while line low", 1, 0);
    end
    ext_low = 1'b0;
    k_rel = -1; vld = 1'b0;
    for (int k = 1; k <= HOLD + 20 && k_rel < 0; k++) begin
      @(negedge clk);
      if (core_rst_n) begin
        k_rel = k;
        vld   = boot_valid;
      end
    end
    chk(in_window(k_rel), "R7", "edges to warm release", k_rel, HOLD);
    chk(vld, "R5", "strobe at warm release", vld, 1);
    chk(boot_word == word, "R7", "boot word kept", boot_word, word);
  endtask

  initial begin
    logic [W-1:0] w;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(pack() == cold_pack_exp(), "R1", "reset state", pack(), cold_pack_exp());

    w = W'($urandom);
    cold_seq(w, 5, 1'b0, "R1");
    warm_seq(5 + int'($urandom % 50), w);

    w = 16'hffff;
    cold_seq(w, 3000, 1'b1, "R2"); // long pulse with a noisy bus
    warm_seq(5 + int'($urandom % 50), w);

    w = 16'h0000;
    cold_seq(w, 2, 1'b1, "R1");

    for (int n = 0; n < 3; n++) begin
      w = W'($urandom);
      cold_seq(w, 4 + int'($urandom % 100), 1'b1, "R1");
      if (n == 1) warm_seq(5 + int'($urandom % 50), w);
    end

    // R8: cold reset lands during a warm hold count
    @(negedge clk);
    ext_low = 1'b1;
    repeat (10) @(negedge clk);
    ext_low = 1'b0;
    repeat (100) @(negedge clk);
    chk(!core_rst_n, "R8", "still counting after warm", core_rst_n, 0);
    w = ~w;
    cold_seq(w, 20, 1'b1, "R8");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule